// File: doc/BRIEF.md
# Guarded Clock Prescaler

This block divides a source clock by a power of two and hands downstream synchronous logic a one-cycle enable pulse, `tick_en`, once per divided period. The division factor sits in a small control register on a byte-wide write port clocked by the undivided source clock. That register is protected. A new ratio is taken only when it arrives shortly after a separate arming write. A stray store therefore cannot change the clock rate.

To change the ratio, software first writes the arming value, which has only the arm bit set. It then writes the new ratio code, with the arm bit clear, on one of the next four source-clock edges. If no ratio write arrives in that window, the arm bit drops back to zero on its own, and later ratio writes are ignored. A configuration input picks the start-up ratio: divide by one, or divide by eight for a source that is too fast for the logic it feeds. An accepted ratio is held as pending and moves into the divider only at the end of the current divided period, so every period is a whole number of source cycles.

The read port, `rd_data`, returns the arm state and the ratio code that was accepted most recently.

Top module: `clkdiv_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, the ratio code is 3 (divide by 8) when `div8_cfg` is 1 and 0 (divide by 1) when `div8_cfg` is 0. The window is closed, so `rd_data` reads 8'h03 or 8'h00.
- R2: A write of exactly 8'h80 opens the window. `rd_data[7]` (the arm bit) reads 1 from the next cycle on, for as long as the window is open.
- R3: A write that has bit 7 set together with any other bit does not open the window and changes nothing.
- R4: A ratio write is a write with bit 7 clear. It is accepted on any of the four clock edges that follow the arming edge. After the fourth edge the arm bit reads 0 and ratio writes are ignored. A further 8'h80 write restarts the four-edge window, and other bit-7-set writes leave the window running.
- R5: An accepted ratio write with code `wr_data[3:0]` in 0..8 becomes the code shown in `rd_data[3:0]` from the next cycle on. It also closes the window.
- R6: A ratio write in the window with a reserved code (9..15) closes the window and leaves the ratio unchanged.
- R7: With ratio code c active, `tick_en` is high for exactly one source cycle in every 2^c cycles. With code 0 it is high on every cycle.
- R8: A newly accepted code takes effect on the clock edge that ends the current divided period. The next period then has the full new length.
- R9: Every legal code can be written through the unlock sequence, whatever the value of `div8_cfg`.
- R10: `rd_data` bits 6:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div8_cfg | input | 1 | Selects divide-by-8 as the reset ratio when 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 7 is the arm bit, bits 3:0 the ratio code |
| rd_data | output | 8 | Arm state in bit 7, most recently accepted ratio code in bits 3:0 |
| tick_en | output | 1 | One-cycle enable pulse, once per divided period |

## Verification
Every write is seen by the register on the clock edge after it is driven. Its effect on `rd_data` is visible one cycle after that edge, with no further register stages in between. `tick_en` is decoded from the divider counter with no extra register, so a code change appears in the pulse spacing right after the period boundary that takes it in. The bench drives inputs just after a falling edge and samples outputs on the next falling edge. A behavioural model in the bench advances once per rising edge and predicts both outputs for every cycle. Because the model applies pending ratios only at its own period ends, any early or late change of the pulse spacing shows up as a mismatch on that exact cycle.

// File: rtl/clkdiv_guard_pkg.sv
package clkdiv_guard_pkg;

  localparam int CODE_W   = 4;
  localparam int CNT_W    = 8;
  localparam int MAX_CODE = 8;
  localparam int DIV8_CODE = 3;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // legal ratio codes stop at MAX_CODE; larger codes are reserved
  function automatic logic code_legal(input code_t c);
    return c <= code_t'(MAX_CODE);
  endfunction

  // terminal count for a factor of 2**c: the low c bits all ones
  function automatic cnt_t term_count(input code_t c);
    cnt_t t;
    t = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(c)) t[i] = 1'b1;
    end
    return t;
  endfunction

  // ratio code loaded by reset, chosen by the configuration input
  function automatic code_t reset_code(input logic div8);
    return div8 ? code_t'(DIV8_CODE) : code_t'(0);
  endfunction

endpackage

// File: rtl/cdg_unlock.sv
module cdg_unlock
  import clkdiv_guard_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ARM_BIT = 7,
  parameter int WIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              win_open,
  output logic              unlock_hit,
  output logic              ratio_wr
);

  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam logic [DATA_W-1:0] ARM_VAL = DATA_W'(1) << ARM_BIT;

  logic [WIN_W-1:0] win_cnt;

  // only the bare arm value opens the window
  assign unlock_hit = wr_en && (wr_data == ARM_VAL);
  // a write with the arm bit clear while armed is the ratio step
  assign ratio_wr   = wr_en && win_open && !wr_data[ARM_BIT];
  assign win_open   = (win_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (unlock_hit) begin
      win_cnt <= WIN_W'(WIN_CYC);
    end else if (ratio_wr) begin
      win_cnt <= '0;
    end else if (win_open) begin
      win_cnt <= win_cnt - WIN_W'(1);
    end
  end

endmodule

// File: rtl/cdg_ratio.sv
module cdg_ratio
  import clkdiv_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  div8_cfg,
  input  logic  ratio_wr,
  input  code_t wr_code,
  input  logic  period_end,
  output logic  accept,
  output logic  apply,
  output code_t act_code,
  output code_t shown_code
);

  logic  pend_valid;
  code_t pend_code;

  assign accept     = ratio_wr && code_legal(wr_code);
  assign apply      = period_end && pend_valid;
  assign shown_code = pend_valid ? pend_code : act_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= reset_code(div8_cfg);
    end else if (apply) begin
      act_code <= pend_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_code  <= '0;
    end else if (accept) begin
      pend_valid <= 1'b1;
      pend_code  <= wr_code;
    end else if (apply) begin
      pend_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cdg_divider.sv
module cdg_divider
  import clkdiv_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t act_code,
  output logic  tick,
  output cnt_t  cnt
);

  cnt_t term;

  assign term = term_count(act_code);
  assign tick = (cnt == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + cnt_t'(1);
    end
  end

endmodule

// File: rtl/clkdiv_guard.sv
module clkdiv_guard
  import clkdiv_guard_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ARM_BIT = 7,
  parameter int WIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div8_cfg,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick_en
);

  logic  win_open;
  logic  unlock_hit;
  logic  ratio_wr;
  logic  accept;
  logic  apply;
  logic  tick;
  code_t act_code;
  code_t shown_code;
  cnt_t  div_cnt;

  cdg_unlock #(
    .DATA_W (DATA_W),
    .ARM_BIT(ARM_BIT),
    .WIN_CYC(WIN_CYC)
  ) u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .win_open  (win_open),
    .unlock_hit(unlock_hit),
    .ratio_wr  (ratio_wr)
  );

  cdg_ratio u_ratio (
    .clk       (clk),
    .rst_n     (rst_n),
    .div8_cfg  (div8_cfg),
    .ratio_wr  (ratio_wr),
    .wr_code   (wr_data[CODE_W-1:0]),
    .period_end(tick),
    .accept    (accept),
    .apply     (apply),
    .act_code  (act_code),
    .shown_code(shown_code)
  );

  cdg_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_code(act_code),
    .tick    (tick),
    .cnt     (div_cnt)
  );

  assign tick_en = tick;

  always_comb begin
    rd_data                = '0;
    rd_data[ARM_BIT]       = win_open;
    rd_data[CODE_W-1:0]    = shown_code;
  end

endmodule

// File: rtl/clkdiv_guard_chk.sv
module clkdiv_guard_chk
  import clkdiv_guard_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ARM_BIT = 7,
  parameter int WIN_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              win_open,
  input logic              unlock_hit,
  input logic              accept,
  input logic              tick,
  input code_t             act_code
);

  localparam logic [DATA_W-1:0] ARM_VAL  = DATA_W'(1) << ARM_BIT;
  localparam logic [DATA_W-1:0] PAD_MASK =
    ~(ARM_VAL | DATA_W'((1 << CODE_W) - 1));

  int unsigned open_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_run <= 0;
    else if (unlock_hit || !win_open) open_run <= 0;
    else open_run <= open_run + 1;
  end

  // R2: the arming value opens the window
  a_r2_arm_opens: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_hit |=> win_open);

  // R3: a dirty arming write cannot open a closed window
  a_r3_dirty_arm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && wr_en && wr_data[ARM_BIT] && wr_data != ARM_VAL) |=> !win_open);

  // R4: the window never stays open past its edge budget
  a_r4_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    open_run <= WIN_CYC);

  // R5: an accepted ratio write closes the window
  a_r5_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !win_open);

  // R6: a reserved code never reaches the divider
  a_r6_no_reserved_active: assert property (@(posedge clk) disable iff (!rst_n)
    act_code <= code_t'(MAX_CODE));

  // R7: divide-by-one pulses every cycle
  a_r7_code0_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == '0) |-> tick);

  // R8: the active ratio moves only at a period end
  a_r8_change_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(act_code));

  // R10: unused read bits stay zero
  a_r10_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & PAD_MASK) == '0);

endmodule

bind clkdiv_guard clkdiv_guard_chk #(
  .DATA_W (DATA_W),
  .ARM_BIT(ARM_BIT),
  .WIN_CYC(WIN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .win_open  (win_open),
  .unlock_hit(unlock_hit),
  .accept    (accept),
  .tick      (tick),
  .act_code  (act_code)
);

// File: tb/clkdiv_guard_bench.sv
module clkdiv_guard_bench;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div8_cfg = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_win, m_pv, m_pc, m_act, m_cnt;

  always #(PERIOD/2) clk = ~clk;

  clkdiv_guard u_clkdiv_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .div8_cfg(div8_cfg),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick_en (tick_en)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_win = 0; m_pv = 0; m_pc = 0; m_cnt = 0;
      m_act = div8_cfg ? 3 : 0;
    end else begin
      bit period_done;
      bit take;
      period_done = (m_cnt == (1 << m_act) - 1);
      take = 0;
      if (wr_en && wr_data == 8'h80) m_win = 4;
      else if (wr_en && m_win > 0 && !wr_data[7]) begin
        m_win = 0;
        if (wr_data[3:0] <= 4'd8) take = 1;
      end else if (m_win > 0) m_win = m_win - 1;
      if (period_done) begin
        m_cnt = 0;
        if (m_pv != 0) begin m_act = m_pc; m_pv = 0; end
      end else m_cnt = m_cnt + 1;
      if (take) begin m_pv = 1; m_pc = int'(wr_data[3:0]); end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      int exp_rd;
      bit exp_tk;
      exp_tk = (m_cnt == (1 << m_act) - 1);
      exp_rd = ((m_win > 0) ? 8'h80 : 8'h00) | ((m_pv != 0) ? m_pc : m_act);
      check(tick_en == exp_tk, cur_req, int'(tick_en), int'(exp_tk));
      check(int'(rd_data) == exp_rd, cur_req, int'(rd_data), exp_rd);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    rst_n = 1'b0; div8_cfg = cfg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    // R1: reset ratio without divide-by-8
    cur_req = "R1";
    do_reset(1'b0);
    step();
    check(rd_data == 8'h00, "R1", int'(rd_data), 8'h00);
    cur_req = "R7";
    idle(5);

    // R2 and R5: immediate second write of code 2
    cur_req = "R2";
    wr(8'h80);
    step();
    check(rd_data == 8'h80, "R2", int'(rd_data), 8'h80);
    cur_req = "R5";
    wr(8'h02);
    step();
    check(rd_data == 8'h02, "R5", int'(rd_data), 8'h02);
    cur_req = "R8";
    idle(20);

    // R4: ratio write on the fourth edge is still taken
    cur_req = "R4";
    wr(8'h80);
    idle(3);
    wr(8'h05);
    step();
    check(rd_data[3:0] == 4'h5, "R4", int'(rd_data[3:0]), 5);

    // R4: after four idle edges the window is shut
    wr(8'h80);
    idle(4);
    check(rd_data[7] == 1'b0, "R4", int'(rd_data[7]), 0);
    wr(8'h01);
    step();
    check(rd_data == 8'h05, "R4", int'(rd_data), 8'h05);

    // R3: dirty arming write
    cur_req = "R3";
    wr(8'h81);
    check(rd_data[7] == 1'b0, "R3", int'(rd_data[7]), 0);
    wr(8'h01);
    step();
    check(rd_data == 8'h05, "R3", int'(rd_data), 8'h05);

    // R6: reserved code within the window
    cur_req = "R6";
    wr(8'h80);
    wr(8'h0C);
    step();
    check(rd_data == 8'h05, "R6", int'(rd_data), 8'h05);

    // R7 and R8: code 0, then code 8
    cur_req = "R8";
    wr(8'h80);
    wr(8'h00);
    idle(40);
    cur_req = "R7";
    check(tick_en == 1'b1, "R7", int'(tick_en), 1);
    idle(5);
    cur_req = "R8";
    wr(8'h80);
    wr(8'h08);
    idle(600);

    // R1 and R9: divide-by-8 reset, then any code still allowed
    cur_req = "R1";
    do_reset(1'b1);
    step();
    check(rd_data == 8'h03, "R1", int'(rd_data), 8'h03);
    idle(20);
    cur_req = "R9";
    wr(8'h80);
    wr(8'h00);
    step();
    check(rd_data == 8'h00, "R9", int'(rd_data), 8'h00);
    idle(12);

    // R10: stray middle bits in a ratio write never show up
    cur_req = "R10";
    wr(8'h80);
    wr(8'h76);
    step();
    check(rd_data == 8'h06, "R10", int'(rd_data), 8'h06);
    idle(140);

    // R4: re-arming restarts the window
    cur_req = "R4";
    wr(8'h80);
    idle(3);
    wr(8'h80);
    idle(3);
    wr(8'h01);
    step();
    check(rd_data == 8'h01, "R4", int'(rd_data), 8'h01);
    idle(80);

    finish_run();
  end

  initial begin
    #(PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule